// File: doc/BRIEF.md
# Floating-Point Write-Port Slot Guard

This block sits at the issue stage of a pipeline whose floating-point units share one register-file write port. The adder and multiplier are fully pipelined. The divider is not. Every candidate instruction presents its operation class and destination register. The guard answers in the same cycle whether the instruction must be held back.

Three things can hold an instruction back:
- The cycle in which it would write its result is already claimed by an earlier operation.
- It is a divide and the divider is still occupied.
- An older write to the same destination would land later than its own, which would leave the register with the stale value.

Accepted operations claim their write-back cycle in a vector that moves one place toward the present every clock. The vector also reports which register is written in the current cycle.

Unit latencies are parameters, with defaults of 4 cycles for add, 7 for multiply and 24 for divide. An operation accepted in cycle t writes back in cycle t plus its latency.

Top module: `fp_wb_slot_guard`

## Requirements
- R1: An operation of class add (code 1), multiply (code 2) or divide (code 3) accepted in cycle t drives `wb_valid` high in cycle t+4, t+7 or t+24 respectively, with `wb_dst` equal to its destination. `wb_valid` is low in every cycle with no scheduled write-back.
- R2: Add and multiply operations are accepted in consecutive cycles whenever their write-back cycles differ and no other hazard applies.
- R3: An operation whose write-back cycle is already claimed by an accepted operation sees `stall` high, so at most one result is written per cycle.
- R4: `div_busy` is high from the cycle after a divide is accepted through the cycle before its write-back. A divide presented while `div_busy` is high is stalled. A new divide may be accepted in the write-back cycle of the previous one.
- R5: An operation stalls when its destination register has an accepted, not yet written result whose write-back cycle is later than the new operation's own write-back cycle.
- R6: Class code 0 (no floating-point destination), or `iss_valid` low, never raises `stall` and claims no write-back cycle.
- R7: A stalled operation records nothing: it produces no later write-back, does not set `div_busy`, and leaves no pending write on its destination.
- R8: While `rst_n` is low at a clock edge, all claims, pending writes and the divider lock are cleared. After reset, `wb_valid` and `div_busy` are low until new operations are accepted.
- R9: `stall` is a combinational function of the current inputs and the state, valid in the same cycle the operation is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An operation is presented for issue this cycle |
| iss_cls | input | 2 | Operation class: 0 none, 1 add, 2 multiply, 3 divide |
| iss_dst | input | 5 | Floating-point destination register |
| stall | output | 1 | The presented operation must not issue this cycle |
| wb_valid | output | 1 | A floating-point result is written back this cycle |
| wb_dst | output | 5 | Register written back this cycle |
| div_busy | output | 1 | The divider is occupied by an earlier divide |

## Verification
Directed patterns come first:
- Lone operations of each class pin down the three latencies.
- Back-to-back adds separate pipelined acceptance from a port conflict.
- A multiply followed three cycles later by an add lands both on one write-back cycle. This isolates the port check and shows that the stalled add leaves no trace.
- Two divides, the second offered at the write-back cycle of the first, show where the divider lock ends.
- A divide or multiply followed by an add to the same register isolates the write-after-write check from the port check.
- A reset taken while operations are in flight shows that all state is dropped.

A long random stream then follows, using a four-register destination pool so that the port, divider and ordering hazards interleave.

// File: rtl/fp_slot_pkg.sv
// fp_slot_pkg
// Shared operation-class encoding for the write-port slot guard.
// Assumes a two-bit class field presented at issue.
package fp_slot_pkg;

    typedef enum logic [1:0] {
        OPC_NONE = 2'd0,
        OPC_ADD  = 2'd1,
        OPC_MUL  = 2'd2,
        OPC_DIV  = 2'd3
    } fp_opc_e;

endpackage

// File: rtl/wb_slot_ring.sv
// wb_slot_ring
// Vector of write-back claims, one bit per future cycle, with the
// destination register carried beside each bit. Bit 0 is the current
// write-back cycle. The whole vector moves down one place per clock.
// Assumes the caller never claims a bit that is already set, and that
// claim offsets lie between 1 and W.
module wb_slot_ring #(
    parameter int W  = 25,
    parameter int RW = 5,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [CW-1:0] set_lat,
    input  logic [RW-1:0] set_dst,
    input  logic [CW-1:0] probe_lat,
    output logic          probe_hit,
    output logic          wb_valid,
    output logic [RW-1:0] wb_dst
);

    logic [W-1:0]  slot_q;
    logic [RW-1:0] dst_q [W];

    for (genvar k = 0; k < W; k++) begin : g_slot
        logic          up_bit;
        logic [RW-1:0] up_dst;
        logic          hit;

        if (k == W - 1) begin : g_top
            assign up_bit = 1'b0;
            assign up_dst = '0;
        end else begin : g_mid
            assign up_bit = slot_q[k+1];
            assign up_dst = dst_q[k+1];
        end

        // A claim at latency L lands at index L-1 after this edge.
        assign hit = set_en && (set_lat == CW'(k + 1));

        // Shift the slot toward write-back and merge a new claim.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[k] <= 1'b0;
                dst_q[k]  <= '0;
            end else begin
                slot_q[k] <= up_bit | hit;
                dst_q[k]  <= hit ? set_dst : up_dst;
            end
        end
    end

    // Look up the slot at the requested latency offset.
    always_comb begin
        probe_hit = 1'b0;
        for (int k = 0; k < W; k++) begin
            if (probe_lat == CW'(k)) probe_hit = slot_q[k];
        end
    end

    assign wb_valid = slot_q[0];
    assign wb_dst   = slot_q[0] ? dst_q[0] : '0;

endmodule

// File: rtl/waw_tracker.sv
// waw_tracker
// One countdown per floating-point register. A non-zero count C means
// a result for that register writes back C-1 cycles from now. Reports
// a hazard when that pending write lands after the write a new
// operation of latency L would make. Assumes at most one claim per
// clock.
module waw_tracker #(
    parameter int NREG = 32,
    parameter int RW   = 5,
    parameter int CW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [RW-1:0] set_dst,
    input  logic [CW-1:0] set_lat,
    input  logic [RW-1:0] query_dst,
    input  logic [CW-1:0] query_lat,
    output logic          hazard
);

    logic [CW-1:0] cnt_q [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        // Load on claim, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[r] <= '0;
            end else if (set_en && (set_dst == RW'(r))) begin
                cnt_q[r] <= set_lat;
            end else if (cnt_q[r] != '0) begin
                cnt_q[r] <= cnt_q[r] - 1'b1;
            end
        end
    end

    // Pending write lands after ours when C-1 > L.
    always_comb begin
        hazard = ({1'b0, cnt_q[query_dst]} > ({1'b0, query_lat} + 1'b1));
    end

endmodule

// File: rtl/div_lock.sv
// div_lock
// Occupancy lock for the unpipelined divider. Loaded with the divide
// latency when a divide is accepted. Busy stays high until the cycle
// in which that divide writes back. Assumes the caller only starts a
// divide when busy is low.
module div_lock #(
    parameter int CW      = 5,
    parameter int DIV_LAT = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    logic [CW-1:0] cnt_q;

    // Track the cycles left until the divide result is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(DIV_LAT);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // A count of 1 marks the write-back cycle, so the lock is released there.
    assign busy = (cnt_q > CW'(1));

endmodule

// File: rtl/fp_wb_slot_guard.sv
// fp_wb_slot_guard
// Issue-stage hazard guard for floating-point units that share a single
// register write port. It stalls an operation on a write-port conflict,
// an occupied divider, or an older write to the same register that would
// land later. Accepted operations claim their write-back cycle.
// Assumes fixed unit latencies, each at least 1, and that the issue stage
// presents at most one operation per cycle.
module fp_wb_slot_guard
    import fp_slot_pkg::*;
#(
    parameter int NREG    = 32,
    parameter int ADD_LAT = 4,
    parameter int MUL_LAT = 7,
    parameter int DIV_LAT = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       iss_valid,
    input  logic [1:0] iss_cls,
    input  logic [4:0] iss_dst,
    output logic       stall,
    output logic       wb_valid,
    output logic [4:0] wb_dst,
    output logic       div_busy
);

    localparam int MAXAM = (ADD_LAT > MUL_LAT) ? ADD_LAT : MUL_LAT;
    localparam int MAXL  = (MAXAM > DIV_LAT) ? MAXAM : DIV_LAT;
    localparam int W     = MAXL + 1;
    localparam int CW    = $clog2(W + 1);
    localparam int RW    = $clog2(NREG);

    fp_opc_e       opc;
    logic [CW-1:0] lat;
    logic          is_fp;
    logic          port_hit;
    logic          waw_hit;
    logic          div_hit;
    logic          accept;
    logic [RW-1:0] dst;

    assign opc = fp_opc_e'(iss_cls);
    assign dst = iss_dst[RW-1:0];

    // Map the operation class onto its write-back latency.
    always_comb begin
        unique case (opc)
            OPC_ADD: lat = CW'(ADD_LAT);
            OPC_MUL: lat = CW'(MUL_LAT);
            OPC_DIV: lat = CW'(DIV_LAT);
            default: lat = '0;
        endcase
    end

    // Only floating-point results take part in the checks.
    assign is_fp   = iss_valid && (opc != OPC_NONE);
    assign div_hit = (opc == OPC_DIV) && div_busy;

    // Combine the three hazard sources into the issue decision.
    always_comb begin
        stall  = is_fp && (port_hit || waw_hit || div_hit);
        accept = is_fp && !stall;
    end

    wb_slot_ring #(
        .W  (W),
        .RW (RW),
        .CW (CW)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (accept),
        .set_lat   (lat),
        .set_dst   (dst),
        .probe_lat (lat),
        .probe_hit (port_hit),
        .wb_valid  (wb_valid),
        .wb_dst    (wb_dst[RW-1:0])
    );

    if (RW < 5) begin : g_pad
        assign wb_dst[4:RW] = '0;
    end

    waw_tracker #(
        .NREG (NREG),
        .RW   (RW),
        .CW   (CW)
    ) u_waw (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (accept),
        .set_dst   (dst),
        .set_lat   (lat),
        .query_dst (dst),
        .query_lat (lat),
        .hazard    (waw_hit)
    );

    div_lock #(
        .CW      (CW),
        .DIV_LAT (DIV_LAT)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept && (opc == OPC_DIV)),
        .busy  (div_busy)
    );

endmodule

// File: rtl/fp_wb_slot_guard_chk.sv
// fp_wb_slot_guard_chk
// Port-level properties of the slot guard, attached by bind.
module fp_wb_slot_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       iss_valid,
    input logic [1:0] iss_cls,
    input logic       stall,
    input logic       wb_valid,
    input logic       div_busy
);

    // R6: no floating-point destination means no stall.
    a_r6_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!iss_valid || iss_cls == 2'd0) |-> !stall);

    // R4: a divide offered while the divider is occupied is held.
    a_r4_div_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_cls == 2'd3 && div_busy) |-> stall);

    // R7: the lock only rises after an accepted divide.
    a_r7_busy_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_busy) |-> $past(iss_valid && iss_cls == 2'd3 && !stall));

    // R1: the lock releases in the divide's write-back cycle.
    a_r1_div_release_wb: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(div_busy) |-> wb_valid);

    // R8: the first cycle out of reset has no write-back and no lock.
    a_r8_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!wb_valid && !div_busy));

endmodule

bind fp_wb_slot_guard fp_wb_slot_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_cls   (iss_cls),
    .stall     (stall),
    .wb_valid  (wb_valid),
    .div_busy  (div_busy)
);

// File: tb/sim_fp_wb_slot_guard.sv
// sim_fp_wb_slot_guard
// Cycle-accurate behavioural reference of the slot guard, compared with
// the design in every cycle.
module sim_fp_wb_slot_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iss_valid = 1'b0;
    logic [1:0] iss_cls = 2'd0;
    logic [4:0] iss_dst = 5'd0;
    logic       stall;
    logic       wb_valid;
    logic [4:0] wb_dst;
    logic       div_busy;

    int checks = 0;
    int errors = 0;

    // Reference state, keyed by absolute cycle number.
    int now = 0;
    bit claim_at [int];
    int dst_at [int];
    int pend [32];
    int last_div = -1;

    fp_wb_slot_guard u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_valid (iss_valid),
        .iss_cls   (iss_cls),
        .iss_dst   (iss_dst),
        .stall     (stall),
        .wb_valid  (wb_valid),
        .wb_dst    (wb_dst),
        .div_busy  (div_busy)
    );

    always #10 clk = ~clk;

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, now, act, exp);
        end
    endtask

    task automatic model_clear();
        claim_at.delete();
        dst_at.delete();
        for (int i = 0; i < 32; i++) pend[i] = -1;
        last_div = -1;
        now = 0;
    endtask

    // R8: hold reset across two edges, then release it.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        iss_valid = 1'b0;
        iss_cls = 2'd0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        #2;
        chk(wb_valid, 0, "R8 wb_valid");
        chk(div_busy, 0, "R8 div_busy");
        chk(stall, 0, "R8 stall");
    endtask

    // One cycle: drive, compare with the reference, advance the reference.
    task automatic step(input bit v, input int c, input int d);
        int    lat;
        bit    exp_stall;
        bit    exp_busy;
        bit    exp_wb;
        string why;
        @(negedge clk);
        iss_valid = v;
        iss_cls = 2'(c);
        iss_dst = 5'(d);
        #2;
        lat = (c == 1) ? 4 : (c == 2) ? 7 : (c == 3) ? 24 : 0;
        exp_busy = (last_div >= 0) && (now > last_div) && (now < last_div + 24);
        exp_stall = 1'b0;
        why = "R2 R9 accept";
        if (v && c != 0) begin
            if (claim_at.exists(now + lat)) begin
                exp_stall = 1'b1; why = "R3 R9 port";
            end else if (c == 3 && exp_busy) begin
                exp_stall = 1'b1; why = "R4 R9 divider";
            end else if (pend[d] > now + lat) begin
                exp_stall = 1'b1; why = "R5 R9 order";
            end
        end else begin
            why = "R6 no-fp";
        end
        chk(stall, exp_stall, why);
        exp_wb = claim_at.exists(now);
        chk(wb_valid, exp_wb, exp_wb ? "R1 wb_valid" : "R7 R6 no wb");
        if (exp_wb) chk(wb_dst, dst_at[now], "R1 wb_dst");
        chk(div_busy, exp_busy, "R4 R7 div_busy");
        if (v && c != 0 && !exp_stall) begin
            claim_at[now + lat] = 1'b1;
            dst_at[now + lat] = d;
            pend[d] = now + lat;
            if (c == 3) last_div = now;
        end
        now++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0);
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_clear();
        do_reset();
        // R1: a lone operation of each class.
        step(1, 1, 3); idle(6);
        step(1, 2, 4); idle(9);
        step(1, 3, 5); idle(26);
        // R2: back-to-back adds, then a multiply.
        step(1, 1, 1); step(1, 1, 2); step(1, 1, 6); step(1, 2, 7); idle(10);
        // R3 and R7: a multiply and then an add three cycles later target the same slot.
        step(1, 2, 1); idle(2); step(1, 1, 3); idle(8);
        // R4: a second divide is held, then accepted in the write-back cycle of the first.
        step(1, 3, 8); step(1, 3, 9); idle(22); step(1, 3, 9); step(1, 3, 10); idle(26);
        // R5: an add behind a divide and behind a multiply to the same register.
        step(1, 3, 2); step(1, 1, 2); idle(24);
        step(1, 2, 6); step(1, 1, 6); idle(3); step(1, 1, 6); idle(8);
        // R6: a valid operation with class 0 is ignored.
        step(1, 0, 11); step(1, 0, 12); idle(8);
        // R8: reset while operations are in flight.
        step(1, 3, 1); step(1, 2, 2); step(1, 1, 3);
        do_reset();
        idle(30);
        // Random stream over a small register pool.
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 4) != 0, int'($urandom % 4), int'($urandom % 4));
        end
        idle(30);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule